// File: doc/BRIEF.md
# Flux-Transition Bit-Cell Clock Recovery

This block recovers bit cells from the raw pulse train of a disk read head. Every flux transition is passed through a synchroniser and an edge detector, then through a short hold-off filter. Each transition that the filter lets through restarts a clock prescaler and a 4-bit cell counter. The prescaler divides the system clock by a ratio chosen with a 2-bit zone selector, and each prescaler wrap advances the cell counter by one step. Four steps make one bit cell. Once per cell, at the middle phase, the block raises a one-cycle bit tick with a data bit. The bit is one in the first cell after a transition and zero in the cells that follow.

The scheme does not track phase. It only restarts its timing on each transition, so it is not a true phase-locked loop. The cell counter is four bits wide and wraps after four cells. Because of this, a long gap with no transitions reads back as a one followed by three zeros, over and over. The same bit tick can also time a write stream, because when no pulses arrive it runs freely at the rate of the selected zone.

Top module: `bitcell_recover`

## Requirements
- R1: When a rising edge of `fluxIn` is accepted, the prescaler and the cell counter restart. Acceptance takes effect on the third rising clock edge after `fluxIn` goes high. The next tick comes 2·D clock edges after the accepting edge and carries `bitVal`=1.
- R2: While no transition is accepted, a tick occurs every 4·D clock cycles. Each tick that falls in a cell with no transition carries `bitVal`=0.
- R3: With no transitions, the cell counter wraps after 16 steps. The tick values then repeat the pattern 1,0,0,0, and no tick carrying 0 is ever preceded by three zero ticks in a row.
- R4: The step divisor is D = 16 − `zoneSel`, so zone 0 divides by 16, zone 1 by 15, zone 2 by 14 and zone 3 by 13.
- R5: A rising edge that would take effect fewer than HOLDOFF clock cycles after the previously accepted edge is ignored and changes no output timing. An edge exactly HOLDOFF cycles later is accepted.
- R6: While `rstN` is low, `bitTick` and `bitVal` are 0. Release of reset acts as an acceptance on the edge just before release, so the first tick follows 2·D edges later.
- R7: `bitTick` is high for exactly one cycle per cell. `bitVal` changes only together with a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fluxIn | input | 1 | Raw flux-transition pulse from the head amplifier (asynchronous) |
| zoneSel | input | 2 | Speed-zone selector; the step divisor is 16 − zoneSel |
| bitTick | output | 1 | One-cycle strobe once per recovered bit cell |
| bitVal | output | 1 | Recovered data bit, valid with bitTick |

## Verification
Free-running runs with no pulses, in the fastest and the slowest zone, confirm the wrap pattern and the cell period. These runs separate a wrong divisor from a wrong tick phase. Pulses placed exactly one cell apart and then two cells apart produce all ones and then alternating one and zero, which shows that each accepted transition restarts the timing. Two runs probe the hold-off filter with pulses one cycle inside and exactly on the window edge; whether the tick times shift tells the two cases apart. Seeded random pulse spacings in random zones then mix short, long and filtered gaps, and every tick time and value is compared against a model built from the requirements.

// File: rtl/bcr_pkg.sv
`timescale 1ns/1ps
package bcr_pkg;
  // Strobes handed from the control side to the bit datapath.
  typedef struct packed {
    logic accept;  // accepted flux transition: restart cell timing
    logic step;    // one cell-counter step (prescaler wrap)
  } bcrStrobe_t;
endpackage

// File: rtl/bcr_ctrl.sv
`timescale 1ns/1ps
module bcr_ctrl
  import bcr_pkg::*;
#(
  parameter int BASE_DIV    = 16,
  parameter int ZONE_W      = 2,
  parameter int HOLDOFF     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fluxIn,
  input  logic [ZONE_W-1:0] zoneSel,
  output bcrStrobe_t        strobe
);
  localparam int PRE_W = $clog2(BASE_DIV);
  localparam int HC_W  = $clog2(HOLDOFF + 1);
  localparam int GAP_W = PRE_W + 1;

  // Synchroniser chain, then one more flop for edge detection.
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   edgeQ;
  logic                   fluxRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      edgeQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], fluxIn};
      edgeQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign fluxRise = syncQ[SYNC_STAGES-1] & ~edgeQ;

  // Hold-off filter: reject rises that come too close to the last accepted one.
  logic [HC_W-1:0] holdCnt;
  logic            accept;

  assign accept = fluxRise && (holdCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (accept) begin
      holdCnt <= HC_W'(HOLDOFF - 1);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  // Zone prescaler: wraps every (BASE_DIV - zoneSel) clocks.
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divMax;
  logic             preWrap;

  assign divMax  = PRE_W'(BASE_DIV - 1) - PRE_W'(zoneSel);
  assign preWrap = (preCnt >= divMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (accept || preWrap) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign strobe.accept = accept;
  assign strobe.step   = preWrap && !accept;

  // Checker state: clocks since the last step or restart.
  logic [GAP_W-1:0] gapCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.step || strobe.accept) begin
      gapCnt <= '0;
    end else if (gapCnt != '1) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // R5
  accept_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> !strobe.accept);

  // R4
  step_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (gapCnt < GAP_W'(BASE_DIV)));

  // R1
  restart_no_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> !strobe.step);

  initial begin
    holdoff_param_chk: assert (HOLDOFF >= 2 && SYNC_STAGES >= 2);
  end
endmodule

// File: rtl/bcr_datapath.sv
`timescale 1ns/1ps
module bcr_datapath
  import bcr_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int PH_W  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  bcrStrobe_t strobe,
  output logic       bitTick,
  output logic       bitVal
);
  localparam logic [PH_W-1:0] TICK_PHASE = PH_W'((1 << (PH_W - 1)) - 1);
  localparam int              CELL_W     = CNT_W - PH_W;

  logic [CNT_W-1:0] cellCnt;
  logic             tickNow;

  assign tickNow = strobe.step && (cellCnt[PH_W-1:0] == TICK_PHASE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellCnt <= '0;
    end else if (strobe.accept) begin
      cellCnt <= '0;
    end else if (strobe.step) begin
      cellCnt <= cellCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitTick <= 1'b0;
      bitVal  <= 1'b0;
    end else begin
      bitTick <= tickNow;
      if (tickNow) begin
        bitVal <= (cellCnt[CNT_W-1:PH_W] == CELL_W'(0));
      end
    end
  end

  // Checker state: zero ticks seen since the last one tick.
  logic [2:0] zeroRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun <= '0;
    end else if (bitTick) begin
      zeroRun <= bitVal ? 3'd0 : ((zeroRun == 3'd7) ? zeroRun : zeroRun + 3'd1);
    end
  end

  // R7
  single_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);

  // R7
  val_with_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bitVal) |-> bitTick);

  // R3
  zero_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && !bitVal) |-> (zeroRun < 3'd3));

  // R1
  accept_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> !bitTick);
endmodule

// File: rtl/bitcell_recover.sv
`timescale 1ns/1ps
module bitcell_recover
  import bcr_pkg::*;
#(
  parameter int BASE_DIV = 16,
  parameter int ZONE_W   = 2,
  parameter int HOLDOFF  = 20,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fluxIn,
  input  logic [ZONE_W-1:0] zoneSel,
  output logic              bitTick,
  output logic              bitVal
);
  bcrStrobe_t strobe;

  bcr_ctrl #(
    .BASE_DIV   (BASE_DIV),
    .ZONE_W     (ZONE_W),
    .HOLDOFF    (HOLDOFF),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .fluxIn (fluxIn),
    .zoneSel(zoneSel),
    .strobe (strobe)
  );

  bcr_datapath #(
    .CNT_W(CNT_W),
    .PH_W (2)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .bitTick(bitTick),
    .bitVal (bitVal)
  );
endmodule

// File: tb/bitcell_recover_tb.sv
`timescale 1ns/1ps
module bitcell_recover_tb;
  localparam int HOLDOFF = 20;
  localparam int MAXN    = 512;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fluxIn = 1'b0;
  logic [1:0] zoneSel = 2'd0;
  logic       bitTick;
  logic       bitVal;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  int obsCyc [MAXN];
  int obsVal [MAXN];
  int nObs = 0;
  bit collect = 0;
  bit prevTick = 0;
  int doubleTicks = 0;
  int spacing [16];

  always #4 clk = ~clk;  // 125 MHz

  bitcell_recover #(.HOLDOFF(HOLDOFF)) u_dut (
    .clk(clk), .rstN(rstN), .fluxIn(fluxIn), .zoneSel(zoneSel),
    .bitTick(bitTick), .bitVal(bitVal)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor samples shortly after each rising edge, away from the edge itself.
  always @(posedge clk) begin
    #2;
    if (collect) begin
      if (bitTick && nObs < MAXN) begin
        obsCyc[nObs] = cyc;
        obsVal[nObs] = int'(bitVal);
        nObs++;
      end
      if (bitTick && prevTick) doubleTicks++;
    end
    prevTick = bitTick;
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runScenario(input string name, input int zone, input int nP,
                             input int lead, input int tail);
    int d, r, p, a, lastA, endC, nAcc, nExp, nxt, t, m;
    bit haveLast;
    int acc [17];
    int expCyc [MAXN];
    int expVal [MAXN];
    d = 16 - zone;
    @(negedge clk);
    rstN = 1'b0;
    fluxIn = 1'b0;
    zoneSel = 2'(zone);
    repeat (3) @(negedge clk);
    checkEq({name, " R6 tick in reset"}, int'(bitTick), 0);
    checkEq({name, " R6 val in reset"}, int'(bitVal), 0);
    rstN = 1'b1;
    r = cyc;
    nObs = 0;
    doubleTicks = 0;
    collect = 1;
    nAcc = 1;
    acc[0] = r;
    haveLast = 0;
    lastA = 0;
    repeat (lead) @(negedge clk);
    for (int i = 0; i < nP; i++) begin
      p = cyc;
      fluxIn = 1'b1;
      a = p + 3;
      if (!haveLast || (a - lastA) >= HOLDOFF) begin
        acc[nAcc] = a;
        nAcc++;
        lastA = a;
        haveLast = 1;
      end
      repeat (2) @(negedge clk);
      fluxIn = 1'b0;
      repeat (spacing[i] - 2) @(negedge clk);
    end
    repeat (tail) @(negedge clk);
    endC = cyc;
    collect = 0;
    // Expected ticks from the requirements (R1..R4).
    nExp = 0;
    for (int k = 0; k < nAcc; k++) begin
      nxt = (k < nAcc - 1) ? acc[k + 1] : endC + 1;
      m = 0;
      t = acc[k] + 2 * d;
      while (t < nxt && t <= endC && nExp < MAXN) begin
        expCyc[nExp] = t;
        expVal[nExp] = (m % 4 == 0) ? 1 : 0;
        nExp++;
        m++;
        t = acc[k] + 2 * d + 4 * d * m;
      end
    end
    checkEq({name, " R2 tick count"}, nObs, nExp);
    for (int i = 0; i < nExp && i < nObs; i++) begin
      checkEq({name, " R1/R4 tick time"}, obsCyc[i] - r, expCyc[i] - r);
      checkEq({name, " R3 tick value"}, obsVal[i], expVal[i]);
    end
    checkEq({name, " R7 back-to-back ticks"}, doubleTicks, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int z, n;
    void'($urandom(32'h5eed_1541));
    // R3, R4: free-running, fastest and slowest zones
    runScenario("free zone0", 0, 0, 0, 8 * 4 * 16);
    runScenario("free zone3", 3, 0, 0, 8 * 4 * 13);
    // R1: one pulse per cell gives all ones
    for (int i = 0; i < 6; i++) spacing[i] = 4 * 14;
    runScenario("one-per-cell", 2, 6, 5, 100);
    // R2: one pulse every two cells gives 1,0
    for (int i = 0; i < 6; i++) spacing[i] = 8 * 15;
    runScenario("every-two-cells", 1, 6, 7, 100);
    // R5: second pulse one cycle inside hold-off is ignored
    spacing[0] = HOLDOFF - 1; spacing[1] = 90; spacing[2] = 40;
    runScenario("R5 inside window", 0, 3, 3, 150);
    // R5: second pulse exactly at hold-off is accepted
    spacing[0] = HOLDOFF; spacing[1] = 90; spacing[2] = 40;
    runScenario("R5 on window edge", 0, 3, 3, 150);
    // Random mix of spacings and zones
    for (int s = 0; s < 10; s++) begin
      z = int'($urandom_range(3, 0));
      n = int'($urandom_range(8, 3));
      for (int i = 0; i < n; i++) spacing[i] = int'($urandom_range(150, 4));
      runScenario($sformatf("random%0d", s), z, n, int'($urandom_range(40, 1)), 200);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule